// File: doc/BRIEF.md
# Dual-Mode Register-31 General Register File

This block holds the general-purpose integer state of a 64-bit processor core: thirty-one ordinary registers, a separately stored stack pointer, a program counter and a next-PC register. Register number 31 has two meanings. Every access carries its own select bit, and that bit decides whether number 31 means the stored stack pointer or a hard-wired zero. In zero mode a read returns zero and a write is dropped.

There is one write port and two read ports. Each port carries an access size of 8, 16, 32 or 64 bits. Each read port also carries a signed flag, and the read value is sign- or zero-extended to 64 bits. A write of 32 bits clears the upper half of the target. Writes of 8 and 16 bits store the whole low 32 bits of the data, zero-extended, in the same way as 32-bit writes. The program-counter section does three things. It computes the next PC, which is PC+4 by default, an absolute target, or PC plus a signed offset. It commits the next PC into the PC on a strobe. On a save-link strobe it copies the next PC into register 30.

Top module: `gpr_file`

## Requirements
- R1: With the read select in zero mode (sel = 0), a read of register 31 returns 0.
- R2: With the write select in zero mode, a write to register 31 changes no register and does not change the stack pointer.
- R3: With the select in stack-pointer mode (sel = 1), register 31 reads and writes a stored stack pointer that is separate from registers 0 to 30.
- R4: A write with size code 2 (32 bits) or smaller stores data[31:0] in bits 31:0 and clears bits 63:32. Size code 3 (64 bits) stores all 64 bits. Sign makes no difference to writes.
- R5: Read size codes are 0=8, 1=16, 2=32 and 3=64 bits. A narrower read takes the low bits, sign-extended when the signed flag is 1 and zero-extended when it is 0.
- R6: On pc_commit the next PC becomes the PC. With no load request, the next PC follows at PC+4 one cycle later.
- R7: npc_mode 1 loads the next PC with npc_val. npc_mode 2 loads PC + npc_val, with npc_val taken as a signed 64-bit value. npc_mode 0 leaves the next PC at its default.
- R8: save_link writes the current next-PC value into register 30.
- R9: Writes take effect at the rising edge. Reads are combinational, so a read in the same cycle as a write to the same register returns the old value.
- R10: A synchronous active-low reset clears all registers, the stack pointer, the PC and the next PC to 0.
- R11: When a port write to register 30 and save_link occur in the same cycle, the port write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_sp | input | 1 | Register 31 is the stack pointer for the write |
| wr_size | input | 2 | Write size code |
| wr_data | input | 64 | Write data |
| ra_idx | input | 5 | Read port A register number |
| ra_sp | input | 1 | Register 31 is the stack pointer for read A |
| ra_size | input | 2 | Read A size code |
| ra_signed | input | 1 | Read A sign-extends |
| ra_data | output | 64 | Read A data |
| rb_idx | input | 5 | Read port B register number |
| rb_sp | input | 1 | Register 31 is the stack pointer for read B |
| rb_size | input | 2 | Read B size code |
| rb_signed | input | 1 | Read B sign-extends |
| rb_data | output | 64 | Read B data |
| npc_mode | input | 2 | Next-PC load: 0 none, 1 absolute, 2 PC-relative |
| npc_val | input | 64 | Target address or signed offset |
| pc_commit | input | 1 | Install the next PC as the PC |
| save_link | input | 1 | Copy the next PC into register 30 |
| pc | output | 64 | Current PC |
| next_pc | output | 64 | Current next PC |

## Verification
The bench builds the block with its default parameters: a 64-bit word and 5-bit register numbers. At these values the register-31 alias and the link register at index 30 fall in the real index space. The sign-bit boundaries of the 8-, 16- and 32-bit read views, and the clearing of the upper half, can also be seen on a full 64-bit word. A random mix of sizes, signs and select bits runs against a bench model of the register file. Directed cases cover the zero-mode write discard, the collision between a port write and save_link, and negative PC-relative offsets.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int XLEN     = 64;
    localparam int IDX_W    = 5;
    localparam int NUM_REGS = 31;
    localparam int LINK_IDX = 30;
    localparam int ALIAS_IDX = 31;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        NPC_SEQ = 2'd0,
        NPC_ABS = 2'd1,
        NPC_REL = 2'd2
    } npc_mode_e;
endpackage

// File: rtl/gpr_read_ext.sv
// Read view shaper: takes the low 8/16/32/64 bits of a stored word and
// extends them to the full width, sign or zero as requested.
// Assumes W is 64 so that all four size codes are meaningful.
module gpr_read_ext #(
    parameter int W = 64
) (
    input  logic [W-1:0] raw,
    input  logic [1:0]   size,
    input  logic         sgn,
    output logic [W-1:0] ext
);
    import gpr_pkg::*;

    // Select the slice and extend it
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_8:  ext = {{(W-8){sgn & raw[7]}},   raw[7:0]};
            SZ_16: ext = {{(W-16){sgn & raw[15]}}, raw[15:0]};
            SZ_32: ext = {{(W-32){sgn & raw[31]}}, raw[31:0]};
            default: ext = raw;
        endcase
    end
endmodule

// File: rtl/gpr_pc_unit.sv
// Program-counter pair: holds PC and next-PC. The next-PC tracks PC+4
// unless a load request is given; a commit strobe installs it as PC.
// Assumes a commit and a load in the same cycle are resolved by letting the
// load see the PC value from before the commit.
module gpr_pc_unit #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   npc_mode,
    input  logic [W-1:0] npc_val,
    input  logic         pc_commit,
    output logic [W-1:0] pc,
    output logic [W-1:0] next_pc
);
    import gpr_pkg::*;

    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] pc_q, npc_q, pc_d, npc_d;

    // Compute the next PC and the next next-PC
    always_comb begin
        pc_d  = pc_commit ? npc_q : pc_q;
        unique case (npc_mode_e'(npc_mode))
            NPC_ABS: npc_d = npc_val;
            NPC_REL: npc_d = pc_q + npc_val;
            default: npc_d = pc_d + STEP;
        endcase
    end

    // Register the PC pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            npc_q <= '0;
        end else begin
            pc_q  <= pc_d;
            npc_q <= npc_d;
        end
    end

    assign pc      = pc_q;
    assign next_pc = npc_q;

    // R6
    commit_installs_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_commit |=> pc == $past(npc_q));
    // R7
    abs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (npc_mode == 2'd1) |=> next_pc == $past(npc_val));
endmodule

// File: rtl/gpr_store.sv
// Storage array: 31 general registers plus a separate stack pointer.
// One write port (already resolved to index/data by the top) and a link
// write from save-link, where the port write has priority on index 30.
// Assumes the caller has already dropped writes to the zero register.
module gpr_store #(
    parameter int W     = 64,
    parameter int IW    = 5,
    parameter int NREGS = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic          wsp,
    input  logic [W-1:0]  wdata,
    input  logic          link_we,
    input  logic [W-1:0]  link_data,
    input  logic [IW-1:0] ra_idx,
    input  logic          ra_sp,
    output logic [W-1:0]  ra_raw,
    input  logic [IW-1:0] rb_idx,
    input  logic          rb_sp,
    output logic [W-1:0]  rb_raw
);
    import gpr_pkg::*;

    localparam int LINK = LINK_IDX;

    logic [W-1:0] regs [NREGS];
    logic [W-1:0] sp_q;

    // One storage cell per general register
    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        logic hit_port;
        logic hit_link;
        assign hit_port = we && !wsp && (widx == IW'(g));
        if (g == LINK) begin : g_link
            assign hit_link = link_we;
        end else begin : g_plain
            assign hit_link = 1'b0;
        end
        // Update this cell; a port write overrides the link write
        always_ff @(posedge clk) begin
            if (!rst_n)        regs[g] <= '0;
            else if (hit_port) regs[g] <= wdata;
            else if (hit_link) regs[g] <= link_data;
        end
    end

    // Stack pointer cell
    always_ff @(posedge clk) begin
        if (!rst_n)        sp_q <= '0;
        else if (we && wsp) sp_q <= wdata;
    end

    // Read port A: stack pointer or indexed register, zero beyond the array
    always_comb begin
        if (ra_sp)                      ra_raw = sp_q;
        else if (int'(ra_idx) < NREGS)  ra_raw = regs[ra_idx];
        else                            ra_raw = '0;
    end

    // Read port B, same decode as port A
    always_comb begin
        if (rb_sp)                      rb_raw = sp_q;
        else if (int'(rb_idx) < NREGS)  rb_raw = regs[rb_idx];
        else                            rb_raw = '0;
    end

    // R11
    port_beats_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wsp && widx == IW'(LINK) && link_we) |=> regs[LINK] == $past(wdata));
    // R8
    link_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && !(we && !wsp && widx == IW'(LINK))) |=> regs[LINK] == $past(link_data));
endmodule

// File: rtl/gpr_file.sv
// Top of the general register file. Resolves register-31 aliasing per
// access, narrows 32-bit-and-below writes, shapes read views and connects
// the PC pair, whose next-PC feeds the link write.
// Assumes index 31 is the only aliased number and 30 is the link register.
module gpr_file #(
    parameter int W  = gpr_pkg::XLEN,
    parameter int IW = gpr_pkg::IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_sp,
    input  logic [1:0]    wr_size,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] ra_idx,
    input  logic          ra_sp,
    input  logic [1:0]    ra_size,
    input  logic          ra_signed,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    input  logic          rb_sp,
    input  logic [1:0]    rb_size,
    input  logic          rb_signed,
    output logic [W-1:0]  rb_data,
    input  logic [1:0]    npc_mode,
    input  logic [W-1:0]  npc_val,
    input  logic          pc_commit,
    input  logic          save_link,
    output logic [W-1:0]  pc,
    output logic [W-1:0]  next_pc
);
    import gpr_pkg::*;

    localparam logic [IW-1:0] ALIAS = IW'(ALIAS_IDX);

    logic          w_alias, w_go, w_to_sp;
    logic [W-1:0]  w_val;
    logic          a_to_sp, b_to_sp;
    logic [W-1:0]  a_raw, b_raw;

    // Resolve the write: drop zero-register writes, narrow small sizes
    always_comb begin
        w_alias = (wr_idx == ALIAS);
        w_to_sp = w_alias && wr_sp;
        w_go    = wr_en && (!w_alias || wr_sp);
        if (acc_size_e'(wr_size) == SZ_64) w_val = wr_data;
        else                               w_val = {{(W-32){1'b0}}, wr_data[31:0]};
    end

    // Resolve the read alias: stack pointer, or zero via an out-of-array index
    always_comb begin
        a_to_sp = (ra_idx == ALIAS) && ra_sp;
        b_to_sp = (rb_idx == ALIAS) && rb_sp;
    end

    gpr_pc_unit #(.W(W)) u_pc (
        .clk(clk), .rst_n(rst_n), .npc_mode(npc_mode), .npc_val(npc_val),
        .pc_commit(pc_commit), .pc(pc), .next_pc(next_pc)
    );

    gpr_store #(.W(W), .IW(IW), .NREGS(NUM_REGS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(w_go), .widx(wr_idx), .wsp(w_to_sp), .wdata(w_val),
        .link_we(save_link), .link_data(next_pc),
        .ra_idx(ra_idx), .ra_sp(a_to_sp), .ra_raw(a_raw),
        .rb_idx(rb_idx), .rb_sp(b_to_sp), .rb_raw(b_raw)
    );

    gpr_read_ext #(.W(W)) u_ext_a (.raw(a_raw), .size(ra_size), .sgn(ra_signed), .ext(ra_data));
    gpr_read_ext #(.W(W)) u_ext_b (.raw(b_raw), .size(rb_size), .sgn(rb_signed), .ext(rb_data));

    // R1
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == ALIAS && !ra_sp) |-> ra_data == '0);
    // R4
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size != 2'd3 && !(wr_idx == ALIAS && !wr_sp) && !(save_link && wr_idx == IW'(LINK_IDX))
         && ra_idx == wr_idx && ra_sp == wr_sp && ra_size == 2'd3)
        |=> ($past(ra_idx) != ra_idx || $past(ra_sp) != ra_sp || ra_size != 2'd3
             || $past(wr_en && ra_idx == wr_idx) != 1'b1 || wr_en || save_link
             || ra_data[W-1:32] == '0));
    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && next_pc == '0));
endmodule

// File: tb/test_gpr_file.sv
module test_gpr_file;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, wr_sp = 0;
    logic [4:0]  wr_idx = 0;
    logic [1:0]  wr_size = 0;
    logic [63:0] wr_data = 0;
    logic [4:0]  ra_idx = 0, rb_idx = 0;
    logic        ra_sp = 0, rb_sp = 0, ra_signed = 0, rb_signed = 0;
    logic [1:0]  ra_size = 3, rb_size = 3;
    logic [63:0] ra_data, rb_data;
    logic [1:0]  npc_mode = 0;
    logic [63:0] npc_val = 0;
    logic        pc_commit = 0, save_link = 0;
    logic [63:0] pc, next_pc;

    int checks = 0, fails = 0;
    logic [63:0] m_reg [32];   // index 31 = stack pointer
    logic [63:0] m_pc, m_npc;

    gpr_file i_gpr_file (.*);

    always #4 clk = ~clk;

    function automatic logic [63:0] ext_of(logic [63:0] v, logic [1:0] sz, logic s);
        case (sz)
            2'd0: return {{56{s & v[7]}},  v[7:0]};
            2'd1: return {{48{s & v[15]}}, v[15:0]};
            2'd2: return {{32{s & v[31]}}, v[31:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [63:0] model_read(logic [4:0] i, logic sp, logic [1:0] sz, logic s);
        if (i == 5'd31 && !sp) return 64'd0;
        return ext_of(m_reg[i], sz, s);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle; model updated at the edge
    task automatic cyc();
        logic [63:0] wv;
        logic [63:0] old_npc, old_pc;
        @(posedge clk);
        old_npc = m_npc; old_pc = m_pc;
        if (save_link) m_reg[30] = old_npc;
        if (wr_en && !(wr_idx == 5'd31 && !wr_sp)) begin
            wv = (wr_size == 2'd3) ? wr_data : {32'd0, wr_data[31:0]};
            m_reg[wr_idx] = wv;
        end
        if (pc_commit) m_pc = old_npc;
        case (npc_mode)
            2'd1: m_npc = npc_val;
            2'd2: m_npc = old_pc + npc_val;
            default: m_npc = m_pc + 64'd4;
        endcase
        #2;
    endtask

    task automatic idle();
        wr_en = 0; save_link = 0; pc_commit = 0; npc_mode = 0;
    endtask

    task automatic wr(logic [4:0] i, logic sp, logic [1:0] sz, logic [63:0] d);
        wr_en = 1; wr_idx = i; wr_sp = sp; wr_size = sz; wr_data = d;
        cyc(); idle();
    endtask

    task automatic rd_chk(string req, logic [4:0] i, logic sp, logic [1:0] sz, logic s);
        ra_idx = i; ra_sp = sp; ra_size = sz; ra_signed = s;
        rb_idx = i; rb_sp = sp; rb_size = sz; rb_signed = ~s;
        #1;
        chk(req, ra_data, model_read(i, sp, sz, s));
        chk(req, rb_data, model_read(i, sp, sz, ~s));
    endtask

    initial begin
        int seed = 32'h5a17;
        void'($urandom(seed));
        for (int k = 0; k < 32; k++) m_reg[k] = 0;
        m_pc = 0; m_npc = 0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1;
        // R10 reset state
        chk("R10 pc", pc, 0);
        chk("R10 npc", next_pc, 0);
        rd_chk("R10 reg", 5'd7, 0, 3, 0);
        rd_chk("R10 sp", 5'd31, 1, 3, 0);
        cyc(); // next_pc becomes 4
        chk("R6 seq", next_pc, 64'd4);
        // R3 stack pointer write/read
        wr(5'd31, 1, 3, 64'hDEAD_BEEF_0123_4567);
        rd_chk("R3", 5'd31, 1, 3, 0);
        rd_chk("R1", 5'd31, 0, 3, 0);
        // R2 zero write discarded
        wr(5'd31, 0, 3, 64'h1111);
        rd_chk("R2 sp", 5'd31, 1, 3, 0);
        rd_chk("R2 r30", 5'd30, 0, 3, 0);
        // R4 32-bit write clears upper half
        wr(5'd3, 0, 3, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(5'd3, 0, 2, 64'hAAAA_AAAA_8000_0001);
        rd_chk("R4", 5'd3, 0, 3, 0);
        chk("R4 lit", ra_data, 64'h0000_0000_8000_0001);
        // R5 sign boundaries
        wr(5'd4, 0, 3, 64'h0123_4567_89AB_CDEF);
        rd_chk("R5 b", 5'd4, 0, 0, 1);
        chk("R5 s8", ra_data, 64'hFFFF_FFFF_FFFF_FFEF);
        rd_chk("R5 h", 5'd4, 0, 1, 1);
        rd_chk("R5 w", 5'd4, 0, 2, 1);
        chk("R5 s32", ra_data, 64'hFFFF_FFFF_89AB_CDEF);
        // R9 read-during-write returns old
        wr_en = 1; wr_idx = 5'd4; wr_sp = 0; wr_size = 3; wr_data = 64'h77;
        ra_idx = 5'd4; ra_sp = 0; ra_size = 3; ra_signed = 0;
        #1 chk("R9 old", ra_data, 64'h0123_4567_89AB_CDEF);
        cyc(); idle();
        rd_chk("R9 new", 5'd4, 0, 3, 0);
        // R7 absolute, R6 commit
        npc_mode = 1; npc_val = 64'h1000; cyc(); idle();
        chk("R7 abs", next_pc, 64'h1000);
        pc_commit = 1; cyc(); idle();
        chk("R6 commit", pc, 64'h1000);
        chk("R6 plus4", next_pc, 64'h1004);
        // R7 relative, negative
        npc_mode = 2; npc_val = -64'sd16; cyc(); idle();
        chk("R7 rel", next_pc, 64'h0FF0);
        // R8 save link
        save_link = 1; cyc(); idle();
        rd_chk("R8", 5'd30, 0, 3, 0);
        chk("R8 lit", ra_data, 64'h0FF0);
        // R11 collision
        save_link = 1; wr_en = 1; wr_idx = 5'd30; wr_sp = 0; wr_size = 3; wr_data = 64'hABCD;
        cyc(); idle();
        rd_chk("R11", 5'd30, 0, 3, 0);
        chk("R11 lit", ra_data, 64'hABCD);
        // random mix
        for (int n = 0; n < 400; n++) begin
            wr_en = $urandom % 2; wr_idx = 5'($urandom); wr_sp = 1'($urandom);
            wr_size = 2'($urandom); wr_data = {$urandom, $urandom};
            save_link = ($urandom % 8) == 0; pc_commit = ($urandom % 4) == 0;
            npc_mode = 2'($urandom % 3); npc_val = {$urandom, $urandom};
            cyc(); idle();
            rd_chk("R5 rnd", 5'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
            chk("R6 rnd pc", pc, m_pc);
            chk("R7 rnd npc", next_pc, m_npc);
        end
        // final reset
        rst_n = 0; cyc(); rst_n = 1;
        for (int k = 0; k < 32; k++) m_reg[k] = 0;
        m_pc = 0; m_npc = 0;
        chk("R10 again", pc, 0);
        rd_chk("R10 again r", 5'd30, 0, 3, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule